// File: doc/BRIEF.md
# Sample-Rate Detector and Clock-Ratio Selector

This block measures how fast a recovered audio word clock (LRCK) toggles by counting cycles of a fixed 24.576 MHz reference clock, which is also the block's own clock. It sorts the measured rate into one of three bands. From that band it picks the system-clock-to-sample-rate ratio that a downstream clock divider should apply. The bit clock is 64fS whatever ratio is chosen, so only the system clock ratio is decided here. Supported sample rates run from 7 kHz to 216 kHz.

The block has two modes. In automatic mode the ratio follows the measured band, but only after two measurements in a row agree. It drops at once to the lowest ratio when the recovery PLL reports loss of lock or the word clock goes silent. In manual mode a three-bit code picks the ratio directly, and a request for the highest ratio is pulled down one step while the measured rate is in the fast band. Every change of the selected ratio is marked by a one-cycle strobe, so the divider can realign.

Top module: `rate_ratio_sel`

## Requirements
- R1: After reset, `period_cnt_o` is 0, `rate_class_o` is 3, `ratio_code_o` is 000, `ratio_chg_o` is 0 and `no_sig_o` is 1.
- R2: `period_cnt_o` gives the number of reference cycles between one LRCK rising edge and the eighth rising edge after it. The first rising edge after reset or after a silence only opens a window. A steady period of P reference cycles yields 8·P.
- R3: Each new count is classified as follows. A count of 3641 or more gives class 0 (54 kHz and below). A count from 1820 to 3640 gives class 1. A count below 1820 gives class 2 (above 108 kHz). Class 3 means no valid measurement.
- R4: In automatic mode with lock, the candidate ratio is code 100 (512fS) for class 0, 010 (256fS) for class 1 and 000 (128fS) for class 2.
- R5: In automatic mode the output ratio takes a new candidate only at a measurement whose candidate equals the candidate of the measurement just before it. A single measurement never moves the ratio.
- R6: In automatic mode, a low `pll_lock_i` or a high `no_sig_o` puts `ratio_code_o` at 000 from the next cycle.
- R7: When no LRCK rising edge arrives for 4096 reference cycles, `no_sig_o` goes to 1, `rate_class_o` becomes 3 and measurement history is discarded. `no_sig_o` clears at the next rising edge.
- R8: While `auto_en_i` is 1, `man_code_i` has no effect on `ratio_code_o`.
- R9: With `auto_en_i` at 0, `man_code_i` values 000, 010 and 100 appear on `ratio_code_o` one cycle later, and every other value gives 000. The lock input has no effect in this mode.
- R10: In manual mode, a request for 100 while `rate_class_o` is 2 yields 010.
- R11: `ratio_chg_o` is high for one cycle in exactly the cycle where `ratio_code_o` shows a new value, and is low otherwise.
- R12: `ratio_code_o` only ever takes the values 000, 010 or 100.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk_i | input | 1 | 24.576 MHz reference clock, also the block clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| lrck_i | input | 1 | Recovered word clock, asynchronous to clk_i |
| pll_lock_i | input | 1 | Recovery PLL lock indication |
| auto_en_i | input | 1 | 1 selects automatic ratio choice |
| man_code_i | input | 3 | Manual ratio request (000, 010, 100) |
| period_cnt_o | output | CNT_W (16) | Reference cycles spanned by the last eight LRCK periods |
| rate_class_o | output | 2 | Rate band: 0 slow, 1 middle, 2 fast, 3 none |
| ratio_code_o | output | 3 | Selected ratio: 000 128fS, 010 256fS, 100 512fS |
| ratio_chg_o | output | 1 | One-cycle strobe on each ratio change |
| no_sig_o | output | 1 | High while the word clock is silent |

## Verification
The hardest state to reach from the ports is the one where the hysteresis history and the lock input interact. The ratio has been forced to 128fS by a lock loss, the history still holds an earlier candidate, and the first measurement after relock must adopt at once because it agrees with that history. The stimulus keeps the word clock steady through a short lock drop, so the measurement window that straddles the drop still falls in the slow band. Window alignment is controlled by inserting a silence longer than the timeout before each rate, which restarts the eight-period window on a known edge. Rates of 456 against 455 cycles and 228 against 227 cycles per period then land exactly on either side of each threshold.

// File: rtl/rrs_pkg.sv
package rrs_pkg;

   typedef enum logic [1:0] {
      CLS_SLOW = 2'd0,
      CLS_MID  = 2'd1,
      CLS_FAST = 2'd2,
      CLS_NONE = 2'd3
   } rate_cls_e;

   typedef enum logic [2:0] {
      RAT_128 = 3'b000,
      RAT_256 = 3'b010,
      RAT_512 = 3'b100
   } ratio_e;

   // Candidate ratio that the automatic mode derives from a rate band.
   function automatic ratio_e ratio_for_class(input rate_cls_e cls);
      case (cls)
         CLS_SLOW: return RAT_512;
         CLS_MID:  return RAT_256;
         default:  return RAT_128;
      endcase
   endfunction

   // Sparse manual code: only three patterns are meaningful.
   function automatic ratio_e ratio_from_code(input logic [2:0] code);
      case (code)
         3'b010:  return RAT_256;
         3'b100:  return RAT_512;
         default: return RAT_128;
      endcase
   endfunction

endpackage

// File: rtl/rrs_edge_sync.sv
module rrs_edge_sync #(
   parameter int STAGES = 2
) (
   input  logic clk_i,
   input  logic rst_ni,
   input  logic async_i,
   output logic rise_o
);

   logic [STAGES-1:0] chain_q;
   logic              prev_q;

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         chain_q <= '0;
         prev_q  <= 1'b0;
      end else begin
         chain_q <= {chain_q[STAGES-2:0], async_i};
         prev_q  <= chain_q[STAGES-1];
      end
   end

   assign rise_o = chain_q[STAGES-1] & ~prev_q;

endmodule

// File: rtl/rrs_period_meter.sv
module rrs_period_meter #(
   parameter int NPER    = 8,
   parameter int CNT_W   = 16,
   parameter int TMO_CYC = 4096
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             rise_i,
   output logic [CNT_W-1:0] meas_o,
   output logic             meas_stb_o,
   output logic             tmo_o,
   output logic             nosig_o
);

   localparam int IDX_W = $clog2(NPER);
   localparam int TMO_W = $clog2(TMO_CYC);
   localparam logic [IDX_W-1:0] IDX_LAST = IDX_W'(NPER - 1);
   localparam logic [TMO_W-1:0] TMO_LAST = TMO_W'(TMO_CYC - 1);
   localparam logic [CNT_W-1:0] CNT_MAX  = '1;

   logic             armed_q;
   logic [IDX_W-1:0] idx_q;
   logic [CNT_W-1:0] win_q;
   logic [TMO_W-1:0] idle_q;
   logic [CNT_W-1:0] meas_q;
   logic             stb_q;
   logic             nosig_q;
   logic [CNT_W-1:0] win_inc;

   assign win_inc = (win_q == CNT_MAX) ? win_q : win_q + CNT_W'(1);

   // Silence is declared in the same cycle the idle counter reaches its
   // limit, so the class register and the silence flag move together.
   assign tmo_o = !nosig_q && !rise_i && (idle_q == TMO_LAST);

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         armed_q <= 1'b0;
         idx_q   <= '0;
         win_q   <= '0;
         idle_q  <= '0;
         meas_q  <= '0;
         stb_q   <= 1'b0;
         nosig_q <= 1'b1;
      end else begin
         stb_q <= 1'b0;
         if (rise_i) begin
            idle_q  <= '0;
            nosig_q <= 1'b0;
            if (!armed_q) begin
               armed_q <= 1'b1;
               idx_q   <= '0;
               win_q   <= '0;
            end else if (idx_q == IDX_LAST) begin
               meas_q <= win_inc;
               stb_q  <= 1'b1;
               idx_q  <= '0;
               win_q  <= '0;
            end else begin
               idx_q <= idx_q + IDX_W'(1);
               win_q <= win_inc;
            end
         end else if (tmo_o) begin
            nosig_q <= 1'b1;
            armed_q <= 1'b0;
            idx_q   <= '0;
            win_q   <= '0;
         end else begin
            if (armed_q) begin
               win_q <= win_inc;
            end
            if (!nosig_q) begin
               idle_q <= idle_q + TMO_W'(1);
            end
         end
      end
   end

   assign meas_o     = meas_q;
   assign meas_stb_o = stb_q;
   assign nosig_o    = nosig_q;

endmodule

// File: rtl/rrs_rate_classify.sv
module rrs_rate_classify
   import rrs_pkg::*;
#(
   parameter int CNT_W = 16,
   parameter int TH_LO = 3641,
   parameter int TH_HI = 1820
) (
   input  logic [CNT_W-1:0] cnt_i,
   output rate_cls_e        cls_o
);

   localparam logic [CNT_W-1:0] LO_C = CNT_W'(TH_LO);
   localparam logic [CNT_W-1:0] HI_C = CNT_W'(TH_HI);

   // A long count means a slow word clock.
   always_comb begin
      if (cnt_i >= LO_C) begin
         cls_o = CLS_SLOW;
      end else if (cnt_i >= HI_C) begin
         cls_o = CLS_MID;
      end else begin
         cls_o = CLS_FAST;
      end
   end

endmodule

// File: rtl/rrs_ratio_select.sv
module rrs_ratio_select
   import rrs_pkg::*;
#(
   parameter int AGREE = 2
) (
   input  logic       clk_i,
   input  logic       rst_ni,
   input  logic       auto_en_i,
   input  logic       lock_i,
   input  logic [2:0] man_code_i,
   input  logic       meas_stb_i,
   input  rate_cls_e  cls_new_i,
   input  rate_cls_e  cls_now_i,
   input  logic       tmo_i,
   input  logic       nosig_i,
   output logic [2:0] ratio_o,
   output logic       chg_o
);

   ratio_e cand;
   ratio_e prev_q;
   ratio_e ratio_q;
   ratio_e ratio_d;
   ratio_e man_sel;
   logic   prev_vld_q;
   logic   adopt;
   logic   chg_q;

   assign cand = ratio_for_class(cls_new_i);

   generate
      if (AGREE == 1) begin : g_direct
         assign adopt = meas_stb_i;
      end else begin : g_two
         assign adopt = meas_stb_i && prev_vld_q && (cand == prev_q);
      end
   endgenerate

   always_comb begin
      man_sel = ratio_from_code(man_code_i);
      if ((man_sel == RAT_512) && (cls_now_i == CLS_FAST)) begin
         man_sel = RAT_256;
      end
      if (auto_en_i) begin
         if (!lock_i || nosig_i) begin
            ratio_d = RAT_128;
         end else if (adopt) begin
            ratio_d = cand;
         end else begin
            ratio_d = ratio_q;
         end
      end else begin
         ratio_d = man_sel;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         ratio_q    <= RAT_128;
         chg_q      <= 1'b0;
         prev_q     <= RAT_128;
         prev_vld_q <= 1'b0;
      end else begin
         ratio_q <= ratio_d;
         chg_q   <= (ratio_d != ratio_q);
         if (meas_stb_i) begin
            prev_q     <= cand;
            prev_vld_q <= 1'b1;
         end else if (tmo_i) begin
            prev_vld_q <= 1'b0;
         end
      end
   end

   assign ratio_o = ratio_q;
   assign chg_o   = chg_q;

endmodule

// File: rtl/rate_ratio_sel.sv
module rate_ratio_sel
   import rrs_pkg::*;
#(
   parameter int  REF_HZ      = 24576000,
   parameter int  NPER        = 8,
   parameter int  LO_HZ       = 54000,
   parameter int  HI_HZ       = 108000,
   parameter int  MIN_HZ      = 7000,
   parameter int  TMO_CYC     = 4096,
   parameter int  SYNC_STAGES = 2,
   parameter int  AGREE       = 2,
   localparam int CNT_W       = $clog2(NPER * TMO_CYC + 1)
) (
   input  logic             clk_i,
   input  logic             rst_ni,
   input  logic             lrck_i,
   input  logic             pll_lock_i,
   input  logic             auto_en_i,
   input  logic [2:0]       man_code_i,
   output logic [CNT_W-1:0] period_cnt_o,
   output logic [1:0]       rate_class_o,
   output logic [2:0]       ratio_code_o,
   output logic             ratio_chg_o,
   output logic             no_sig_o
);

   localparam longint SPAN  = longint'(NPER) * longint'(REF_HZ);
   localparam int     TH_LO = int'((SPAN + longint'(LO_HZ / 2)) / longint'(LO_HZ));
   localparam int     TH_HI = int'((SPAN + longint'(HI_HZ / 2)) / longint'(HI_HZ));
   localparam int     SLOWEST_PER = REF_HZ / MIN_HZ;

   generate
      if (NPER < 2) begin : g_bad_nper
         $error("NPER must be at least 2");
      end
      if (SYNC_STAGES < 2) begin : g_bad_sync
         $error("SYNC_STAGES must be at least 2");
      end
      if ((AGREE != 1) && (AGREE != 2)) begin : g_bad_agree
         $error("AGREE must be 1 or 2");
      end
      if (TH_HI >= TH_LO) begin : g_bad_th
         $error("upper rate threshold must lie above the lower one");
      end
      if (SLOWEST_PER >= TMO_CYC) begin : g_bad_tmo
         $error("silence timeout shorter than the slowest word-clock period");
      end
   endgenerate

   logic             rise;
   logic [CNT_W-1:0] meas;
   logic             meas_stb;
   logic             tmo;
   logic             nosig;
   rate_cls_e        cls_new;
   rate_cls_e        cls_now;
   rate_cls_e        cls_q;

   rrs_edge_sync #(
      .STAGES (SYNC_STAGES)
   ) u_sync (
      .clk_i   (clk_i),
      .rst_ni  (rst_ni),
      .async_i (lrck_i),
      .rise_o  (rise)
   );

   rrs_period_meter #(
      .NPER    (NPER),
      .CNT_W   (CNT_W),
      .TMO_CYC (TMO_CYC)
   ) u_meter (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .rise_i     (rise),
      .meas_o     (meas),
      .meas_stb_o (meas_stb),
      .tmo_o      (tmo),
      .nosig_o    (nosig)
   );

   rrs_rate_classify #(
      .CNT_W (CNT_W),
      .TH_LO (TH_LO),
      .TH_HI (TH_HI)
   ) u_cls (
      .cnt_i (meas),
      .cls_o (cls_new)
   );

   // Band currently in force: a fresh measurement or a silence overrides
   // the stored value in the cycle it happens.
   always_comb begin
      if (meas_stb) begin
         cls_now = cls_new;
      end else if (tmo) begin
         cls_now = CLS_NONE;
      end else begin
         cls_now = cls_q;
      end
   end

   always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni) begin
         cls_q <= CLS_NONE;
      end else begin
         cls_q <= cls_now;
      end
   end

   rrs_ratio_select #(
      .AGREE (AGREE)
   ) u_sel (
      .clk_i      (clk_i),
      .rst_ni     (rst_ni),
      .auto_en_i  (auto_en_i),
      .lock_i     (pll_lock_i),
      .man_code_i (man_code_i),
      .meas_stb_i (meas_stb),
      .cls_new_i  (cls_new),
      .cls_now_i  (cls_now),
      .tmo_i      (tmo),
      .nosig_i    (nosig),
      .ratio_o    (ratio_code_o),
      .chg_o      (ratio_chg_o)
   );

   assign period_cnt_o = meas;
   assign rate_class_o = cls_q;
   assign no_sig_o     = nosig;

endmodule

// File: rtl/rrs_checker.sv
module rrs_checker (
   input logic       clk_i,
   input logic       rst_ni,
   input logic       auto_en_i,
   input logic       pll_lock_i,
   input logic [1:0] rate_class_o,
   input logic [2:0] ratio_code_o,
   input logic       ratio_chg_o,
   input logic       no_sig_o
);

   AST_CHG_ON_MOVE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      ratio_chg_o |-> (ratio_code_o != $past(ratio_code_o))); // R11

   AST_HOLD_QUIET: assert property (@(posedge clk_i) disable iff (!rst_ni)
      !ratio_chg_o |-> $stable(ratio_code_o)); // R11

   AST_CODE_LEGAL: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (ratio_code_o == 3'b000) || (ratio_code_o == 3'b010) || (ratio_code_o == 3'b100)); // R12

   AST_UNLOCK_FORCE: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (auto_en_i && !pll_lock_i) |=> (ratio_code_o == 3'b000)); // R6

   AST_SILENT_CLASS: assert property (@(posedge clk_i) disable iff (!rst_ni)
      no_sig_o |-> (rate_class_o == 2'd3)); // R7

   AST_CLAMP_FAST: assert property (@(posedge clk_i) disable iff (!rst_ni)
      (!$past(auto_en_i) && (rate_class_o == 2'd2)) |-> (ratio_code_o != 3'b100)); // R10

endmodule

bind rate_ratio_sel rrs_checker u_chk (.*);

// File: tb/sim_rate_ratio_sel.sv
module sim_rate_ratio_sel;

   logic        clk     = 1'b0;
   logic        rst_n   = 1'b0;
   logic        lrck    = 1'b0;
   logic        lock    = 1'b1;
   logic        auto_en = 1'b1;
   logic [2:0]  man     = 3'b000;
   logic [15:0] period;
   logic [1:0]  cls;
   logic [2:0]  ratio;
   logic        chg;
   logic        nosig;

   int          n_chk  = 0;
   int          n_fail = 0;
   logic [2:0]  exp_q[$];
   logic [2:0]  mon_exp;

   always #5 clk = ~clk;

   rate_ratio_sel u0 (
      .clk_i        (clk),
      .rst_ni       (rst_n),
      .lrck_i       (lrck),
      .pll_lock_i   (lock),
      .auto_en_i    (auto_en),
      .man_code_i   (man),
      .period_cnt_o (period),
      .rate_class_o (cls),
      .ratio_code_o (ratio),
      .ratio_chg_o  (chg),
      .no_sig_o     (nosig)
   );

   task automatic chk(input string req, input int act, input int exp);
      n_chk++;
      if (act != exp) begin
         n_fail++;
         $display("FAIL %s: actual %0d expected %0d", req, act, exp);
      end
   endtask

   task automatic run_lr(input int p, input int n);
      for (int k = 0; k < n; k++) begin
         lrck = 1'b1;
         repeat (p / 2) @(negedge clk);
         lrck = 1'b0;
         repeat (p - p / 2) @(negedge clk);
      end
   endtask

   task automatic quiet();
      lrck = 1'b0;
      repeat (5000) @(negedge clk);
   endtask

   task automatic expect_chg(input logic [2:0] code);
      exp_q.push_back(code);
   endtask

   task automatic settle();
      repeat (3) @(negedge clk);
   endtask

   task automatic summary();
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
   endtask

   // Monitor: every strobe consumes one expected ratio from the scoreboard.
   always @(negedge clk) begin
      if (rst_n && chg) begin
         n_chk++;
         if (exp_q.size() == 0) begin
            n_fail++;
            $display("FAIL R11: unexpected strobe, actual code %0d expected no change", ratio);
         end else begin
            mon_exp = exp_q.pop_front();
            if (ratio != mon_exp) begin
               n_fail++;
               $display("FAIL R11: strobe code actual %0d expected %0d", ratio, mon_exp);
            end
         end
         n_chk++;
         if (!(ratio == 3'b000 || ratio == 3'b010 || ratio == 3'b100)) begin
            n_fail++;
            $display("FAIL R12: illegal code actual %0d expected 0, 2 or 4", ratio);
         end
      end
   end

   initial begin
      repeat (190000) @(posedge clk);
      n_chk++;
      n_fail++;
      $display("FAIL watchdog: actual hung run expected completion");
      summary();
      $finish;
   end

   initial begin
      repeat (5) @(negedge clk);
      chk("R1 period", period, 0);
      chk("R1 class", cls, 3);
      chk("R1 ratio", ratio, 0);
      chk("R1 strobe", chg, 0);
      chk("R1 no_sig", nosig, 1);
      rst_n = 1'b1;
      settle();

      // 48 kHz-like: 512 cycles per period
      run_lr(512, 9);
      chk("R2 count 8x512", period, 4096);
      chk("R3 class slow", cls, 0);
      chk("R5 single measurement holds", ratio, 0);
      expect_chg(3'b100);
      run_lr(512, 8);
      chk("R4 slow gives 512fS", ratio, 4);

      expect_chg(3'b000);
      quiet();
      chk("R7 no_sig set", nosig, 1);
      chk("R7 class none", cls, 3);
      chk("R6 silence forces 128fS", ratio, 0);

      expect_chg(3'b010);
      run_lr(256, 17);
      chk("R7 no_sig cleared", nosig, 0);
      chk("R2 count 8x256", period, 2048);
      chk("R3 class mid", cls, 1);
      chk("R4 mid gives 256fS", ratio, 2);

      expect_chg(3'b000);
      quiet();
      run_lr(128, 17);
      chk("R2 count 8x128", period, 1024);
      chk("R3 class fast", cls, 2);
      chk("R4 fast gives 128fS", ratio, 0);

      // threshold boundaries
      quiet();
      expect_chg(3'b100);
      run_lr(456, 17);
      chk("R2 count 3648", period, 3648);
      chk("R3 3648 slow", cls, 0);
      chk("R4 3648 ratio", ratio, 4);
      expect_chg(3'b000);
      quiet();
      expect_chg(3'b010);
      run_lr(455, 17);
      chk("R3 3640 mid", cls, 1);
      chk("R4 3640 ratio", ratio, 2);
      expect_chg(3'b000);
      quiet();
      expect_chg(3'b010);
      run_lr(228, 17);
      chk("R3 1824 mid", cls, 1);
      chk("R4 1824 ratio", ratio, 2);
      expect_chg(3'b000);
      quiet();
      run_lr(227, 17);
      chk("R2 count 1816", period, 1816);
      chk("R3 1816 fast", cls, 2);
      chk("R4 1816 ratio", ratio, 0);

      man = 3'b100;
      settle();
      chk("R8 manual ignored in auto", ratio, 0);
      man = 3'b000;

      // lock loss and relock with matching history
      quiet();
      expect_chg(3'b100);
      run_lr(512, 17);
      chk("R4 relock setup", ratio, 4);
      expect_chg(3'b000);
      lock = 1'b0;
      settle();
      chk("R6 unlock forces 128fS", ratio, 0);
      lock = 1'b1;
      settle();
      chk("R5 relock waits for measurement", ratio, 0);
      expect_chg(3'b100);
      run_lr(512, 8);
      chk("R5 relock adopts agreeing candidate", ratio, 4);

      // manual mode
      expect_chg(3'b010);
      auto_en = 1'b0;
      man = 3'b010;
      settle();
      chk("R9 manual 010", ratio, 2);
      expect_chg(3'b100);
      man = 3'b100;
      settle();
      chk("R9 manual 100", ratio, 4);
      expect_chg(3'b000);
      man = 3'b011;
      settle();
      chk("R9 manual illegal gives 000", ratio, 0);
      expect_chg(3'b100);
      man = 3'b100;
      settle();
      lock = 1'b0;
      settle();
      chk("R9 lock ignored in manual", ratio, 4);
      quiet();
      chk("R9 silence ignored in manual", ratio, 4);
      expect_chg(3'b010);
      run_lr(128, 9);
      chk("R3 fast in manual", cls, 2);
      chk("R10 512 clamped at fast rate", ratio, 2);

      expect_chg(3'b000);
      auto_en = 1'b1;
      settle();
      chk("R6 auto while unlocked", ratio, 0);

      repeat (10) @(negedge clk);
      chk("R11 all expected strobes seen", exp_q.size(), 0);
      summary();
      $finish;
   end

endmodule